// File: doc/BRIEF.md
# Video Sync Word Clamp and Preamble Detector

This block sits on a 10-bit parallel video path ahead of a serializer. Each word that arrives on the parallel clock is checked against the reserved ranges used by timing reference codes. A word in the low reserved range leaves the block as 000. A word in the high reserved range leaves as 3FF. The block tests only the eight upper bits, so an 8-bit source whose two low bits are left floating still yields legal 10-bit sync codes. All other words pass through untouched.

A disable input turns clamping off for streams that are not video. The block also marks the three-word timing reference preamble with a single-cycle pulse. The pulse is judged on the words as they leave the block, after clamping. Input and output are both registered, which gives a fixed two-cycle latency.

Top module: `vidSyncClamp`

## Requirements
- R1: A word presented on `dataIn` before rising edge k is captured at edge k. Its result appears on `dataOut` after edge k+1, so the latency is exactly two clock cycles.
- R2: With clamping enabled, any word whose bits 9:2 are all zero (000 to 003 hex) is output as 000.
- R3: With clamping enabled, any word whose bits 9:2 are all one (3FC to 3FF hex) is output as 3FF.
- R4: With clamping enabled, a word whose bits 9:2 are neither all zero nor all one is output unchanged.
- R5: While `syncDisable` is high, every word is output unchanged, including 001 and 3FE. `syncDisable` is sampled on the same edge as the word it applies to.
- R6: `preambleFlag` is high for exactly the one cycle in which `dataOut` shows 000 and the two previous outputs were 3FF then 000. The comparison uses output (post-clamp) values, so the input sequence 3FC, 002, 001 raises the flag.
- R7: With clamping disabled, the inputs 3FC, 001, 000 produce no flag, because the outputs are not exactly 3FF, 000, 000. The exact inputs 3FF, 000, 000 still produce the flag.
- R8: A synchronous active-high `rst` sets `dataOut` to 000 and `preambleFlag` to 0 after the next edge, and clears the preamble history. A preamble interrupted by reset raises no flag.
- R9: Overlapping patterns raise one flag per complete preamble. 3FF, 000, 000, 000 gives a single pulse on the third word. 3FF, 3FF, 000, 000 gives a single pulse on the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 10 | Parallel video word |
| syncDisable | input | 1 | High: pass words unchanged, no clamping |
| dataOut | output | 10 | Clamped word, two cycles after input |
| preambleFlag | output | 1 | One-cycle pulse on the third preamble word at the output |

## Verification
A word driven on a falling edge is captured on the next rising edge. Both its clamped value and its preamble flag are due after the rising edge that follows. The driver stamps every expected item with a due cycle two edges after the edge current at drive time. The monitor samples a short delay after each rising edge and pops only the items whose due cycle matches. Reset checks read the outputs directly after the first edge with reset high, and the monitor is idle while reset is applied.

// File: rtl/vidSyncPkg.sv
package vidSyncPkg;
  localparam int WORD_W = 10;
  localparam int LSB_W  = 2;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_ZERO  = 2'd1,
    CLS_ONES  = 2'd2
  } wordCls_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clampEn;
    logic clearAll;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    wordCls_t nextCls;
  } dpStatus_t;
endpackage

// File: rtl/vidSyncDatapath.sv
module vidSyncDatapath
  import vidSyncPkg::*;
#(
  parameter int WORD_W = vidSyncPkg::WORD_W,
  parameter int LSB_W  = vidSyncPkg::LSB_W
) (
  input  logic              clk,
  input  logic [WORD_W-1:0] dataIn,
  input  ctrlStrobe_t       strobe,
  output logic [WORD_W-1:0] dataOut,
  output dpStatus_t         status
);
  localparam int UP_W = WORD_W - LSB_W;

  logic [WORD_W-1:0] inReg;
  logic [WORD_W-1:0] outReg;
  logic [WORD_W-1:0] clamped;
  logic              upperZero;
  logic              upperOnes;

  always_ff @(posedge clk) begin
    if (strobe.clearAll) inReg <= '0;
    else                 inReg <= dataIn;
  end

  assign upperZero = (inReg[WORD_W-1:LSB_W] == {UP_W{1'b0}});
  assign upperOnes = (inReg[WORD_W-1:LSB_W] == {UP_W{1'b1}});

  always_comb begin
    clamped = inReg;
    if (strobe.clampEn) begin
      if (upperZero)      clamped = '0;
      else if (upperOnes) clamped = '1;
    end
  end

  always_comb begin
    if (clamped == '0)      status.nextCls = CLS_ZERO;
    else if (clamped == '1) status.nextCls = CLS_ONES;
    else                    status.nextCls = CLS_OTHER;
  end

  always_ff @(posedge clk) begin
    if (strobe.clearAll) outReg <= '0;
    else                 outReg <= clamped;
  end

  assign dataOut = outReg;

  AST_LOW_CLAMP: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (strobe.clampEn && upperZero) |=> (dataOut == '0)); // R2
  AST_HIGH_CLAMP: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (strobe.clampEn && upperOnes) |=> (dataOut == '1)); // R3
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (strobe.clearAll)
    (!strobe.clampEn || (!upperZero && !upperOnes)) |=> (dataOut == $past(inReg))); // R4
endmodule

// File: rtl/vidSyncControl.sv
module vidSyncControl
  import vidSyncPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        syncDisable,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        preambleFlag
);
  logic     disReg;
  wordCls_t histNow;   // class of word now on the output
  wordCls_t histPrev;  // class of the output before that
  logic     pulseReg;

  always_ff @(posedge clk) begin
    if (rst) disReg <= 1'b0;
    else     disReg <= syncDisable;
  end

  assign strobe.clampEn  = ~disReg;
  assign strobe.clearAll = rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      histNow  <= CLS_OTHER;
      histPrev <= CLS_OTHER;
      pulseReg <= 1'b0;
    end else begin
      histNow  <= status.nextCls;
      histPrev <= histNow;
      pulseReg <= (histPrev == CLS_ONES) && (histNow == CLS_ZERO)
                  && (status.nextCls == CLS_ZERO);
    end
  end

  assign preambleFlag = pulseReg;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    preambleFlag |=> !preambleFlag); // R9
  AST_PULSE_HISTORY: assert property (@(posedge clk) disable iff (rst)
    $rose(preambleFlag) |-> (histNow == CLS_ZERO && histPrev == CLS_ZERO)); // R6
endmodule

// File: rtl/vidSyncClamp.sv
module vidSyncClamp
  import vidSyncPkg::*;
#(
  parameter int WORD_W = vidSyncPkg::WORD_W,
  parameter int LSB_W  = vidSyncPkg::LSB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              syncDisable,
  output logic [WORD_W-1:0] dataOut,
  output logic              preambleFlag
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  vidSyncControl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .syncDisable  (syncDisable),
    .status       (status),
    .strobe       (strobe),
    .preambleFlag (preambleFlag)
  );

  vidSyncDatapath #(.WORD_W(WORD_W), .LSB_W(LSB_W)) dp_i (
    .clk     (clk),
    .dataIn  (dataIn),
    .strobe  (strobe),
    .dataOut (dataOut),
    .status  (status)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (dataOut == '0 && !preambleFlag)); // R8
endmodule

// File: tb/vidSyncClamp_tb.sv
module vidSyncClamp_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] dataIn = '0;
  logic       syncDisable = 1'b0;
  logic [9:0] dataOut;
  logic       preambleFlag;

  int errors = 0;
  int checks = 0;
  int cycleCnt = 0;
  bit done = 1'b0;

  typedef struct {
    logic [9:0] word;
    logic       pulse;
    int         due;
    string      tag;
  } expItem_t;

  expItem_t   expQ[$];
  logic [9:0] mHist1 = '0;
  logic [9:0] mHist2 = '0;

  always #10 clk = ~clk;

  vidSyncClamp dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .syncDisable(syncDisable),
    .dataOut(dataOut), .preambleFlag(preambleFlag)
  );

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [9:0] modelClamp(logic [9:0] w, logic dis);
    if (!dis && w[9:2] == 8'h00) return 10'h000;
    if (!dis && w[9:2] == 8'hFF) return 10'h3FF;
    return w;
  endfunction

  task automatic sendWord(logic [9:0] w, logic dis, string tag);
    expItem_t it;
    logic [9:0] o;
    @(negedge clk);
    dataIn = w;
    syncDisable = dis;
    o = modelClamp(w, dis);
    it.word  = o;
    it.pulse = (mHist2 == 10'h3FF) && (mHist1 == 10'h000) && (o == 10'h000);
    it.due   = cycleCnt + 2;
    it.tag   = tag;
    mHist2 = mHist1;
    mHist1 = o;
    expQ.push_back(it);
  endtask

  // monitor: compare due items a little after each rising edge
  always @(posedge clk) begin
    #2;
    while (expQ.size() > 0 && expQ[0].due == cycleCnt) begin
      expItem_t it;
      it = expQ.pop_front();
      checks++;
      if (dataOut !== it.word || preambleFlag !== it.pulse) begin
        errors++;
        $display("FAIL %s: dataOut=%h flag=%b expected dataOut=%h flag=%b",
                 it.tag, dataOut, preambleFlag, it.word, it.pulse);
      end
    end
  end

  task automatic doReset(string tag);
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    dataIn = '0;
    syncDisable = 1'b0;
    @(posedge clk);
    #2;
    checks++;
    if (dataOut !== 10'h000 || preambleFlag !== 1'b0) begin
      errors++;
      $display("FAIL %s: dataOut=%h flag=%b expected dataOut=000 flag=0",
               tag, dataOut, preambleFlag);
    end
    @(negedge clk);
    rst = 1'b0;
    mHist1 = '0;
    mHist2 = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    doReset("R8 reset state");

    sendWord(10'h123, 1'b0, "R1 two-cycle latency");
    sendWord(10'h000, 1'b0, "R2 clamp 000");
    sendWord(10'h001, 1'b0, "R2 clamp 001");
    sendWord(10'h002, 1'b0, "R2 clamp 002");
    sendWord(10'h003, 1'b0, "R2 clamp 003");
    sendWord(10'h3FC, 1'b0, "R3 clamp 3FC");
    sendWord(10'h3FD, 1'b0, "R3 clamp 3FD");
    sendWord(10'h3FE, 1'b0, "R3 clamp 3FE");
    sendWord(10'h3FF, 1'b0, "R3 clamp 3FF");
    sendWord(10'h004, 1'b0, "R4 pass 004");
    sendWord(10'h3FB, 1'b0, "R4 pass 3FB");
    sendWord(10'h200, 1'b0, "R4 pass 200");
    sendWord(10'h155, 1'b0, "R4 pass 155");
    sendWord(10'h2AA, 1'b0, "R4 pass 2AA");

    sendWord(10'h001, 1'b1, "R5 disabled 001");
    sendWord(10'h3FE, 1'b1, "R5 disabled 3FE");
    sendWord(10'h002, 1'b1, "R5 disabled 002");
    sendWord(10'h001, 1'b0, "R5 re-enabled 001");

    sendWord(10'h3FF, 1'b0, "R6 preamble w1");
    sendWord(10'h000, 1'b0, "R6 preamble w2");
    sendWord(10'h000, 1'b0, "R6 preamble w3");
    sendWord(10'h155, 1'b0, "R6 after preamble");
    sendWord(10'h3FC, 1'b0, "R6 8-bit preamble w1");
    sendWord(10'h002, 1'b0, "R6 8-bit preamble w2");
    sendWord(10'h001, 1'b0, "R6 8-bit preamble w3");
    sendWord(10'h2AA, 1'b0, "R6 after 8-bit preamble");

    sendWord(10'h3FC, 1'b1, "R7 disabled 3FC");
    sendWord(10'h001, 1'b1, "R7 disabled 001");
    sendWord(10'h000, 1'b1, "R7 disabled 000 no flag");
    sendWord(10'h3FF, 1'b1, "R7 disabled exact w1");
    sendWord(10'h000, 1'b1, "R7 disabled exact w2");
    sendWord(10'h000, 1'b1, "R7 disabled exact w3 flag");

    sendWord(10'h100, 1'b0, "R9 filler");
    sendWord(10'h3FF, 1'b0, "R9 run w1");
    sendWord(10'h000, 1'b0, "R9 run w2");
    sendWord(10'h000, 1'b0, "R9 run w3 flag");
    sendWord(10'h000, 1'b0, "R9 extra zero no flag");
    sendWord(10'h3FF, 1'b0, "R9 double ones a");
    sendWord(10'h3FF, 1'b0, "R9 double ones b");
    sendWord(10'h000, 1'b0, "R9 double zero a");
    sendWord(10'h000, 1'b0, "R9 double zero b flag");
    sendWord(10'h155, 1'b0, "R9 filler end");

    sendWord(10'h3FF, 1'b0, "R8 pre-reset w1");
    sendWord(10'h000, 1'b0, "R8 pre-reset w2");
    doReset("R8 reset mid-preamble");
    sendWord(10'h000, 1'b0, "R8 no flag after reset");
    sendWord(10'h000, 1'b0, "R8 no flag after reset b");

    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule